// File: doc/BRIEF.md
# Stop-Clock Handshake Controller

This block sequences a multi-core processor through an externally requested stop-clock episode. An active-low request pin is first passed through a two-flop synchronizer. When the request is seen, the controller asks the bus for one acknowledge special cycle per die, one die at a time. It waits for each cycle's response-phase strobe before it moves to the next die. After the last response it counts a fixed number of bus clocks, which is always 20 or fewer, and then raises the stop-grant status. At that point every core is moved to the granted state.

Each core is tracked as running, halted or granted. Halt-entry and wake pulses move a core between running and halted while no stop-clock episode is in progress. The state a core held just before stop-grant is saved, and it is restored when the request is released, so a halted core goes back to halted. Releasing the request before stop-grant has been reached breaks the protocol and is flagged. A bus-initialization error event that arrives during stop-grant is held as pending and handed on for service only after the exit. An event that arrives outside stop-grant is handed on at once.

All pins are plain control and status pins. No port carries a data stream, so no port has a valid/ready handshake and no port applies back-pressure.

Top module: `stopclk_ctrl`

## Requirements
- R1: The request pin `stop_req_n` passes through two flops. When it falls, `ack_req[0]` rises on the third rising clock edge after the fall.
- R2: Only one `ack_req` bit is high at a time. Bit d is bit position d of the vector, and die 0 goes first. Bit d stays high until `rsp_strobe` is sampled, and then bit d+1 rises on the next cycle. A `rsp_strobe` sampled while no acknowledge is outstanding has no effect.
- R3: `stop_grant` rises exactly `GRANT_DELAY` clocks (default 4) after the clock edge that samples the last die's `rsp_strobe`. This is never more than 20 clocks.
- R4: While `stop_grant` is high, every 2-bit field of `core_state` reads 2'b10 (granted). Field c is bits [2c+1:2c].
- R5: When the request pin rises during stop-grant, `stop_grant` falls on the third rising edge after the rise. On that same edge each core returns to the state it held before the grant: 2'b01 if halted, 2'b00 if running.
- R6: If the request is released after it has been recognized but before stop-grant, `proto_err` pulses for one cycle, all `ack_req` bits drop, `stop_grant` stays low, and the cores keep their states.
- R7: Halt-entry and wake pulses have no effect on a core while it is granted.
- R8: A `bus_err_evt` during stop-grant sets `err_pending` with no `err_service` pulse. On the exit edge, `err_pending` clears and `err_service` pulses for one cycle.
- R9: A `bus_err_evt` outside stop-grant gives an `err_service` pulse on the next cycle and leaves `err_pending` low. An event in the same cycle as the exit gives exactly one pulse.
- R10: Outside stop-grant, a halt-entry pulse moves a core to halted (2'b01), and a wake pulse moves it to running (2'b00). Wake wins when both pulses arrive together.
- R11: After reset, all outputs are low and every core reads running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req_n | input | 1 | Active-low stop-clock request, asynchronous |
| core_halt_enter | input | N_CORES | Per-core pulse: the core executed a halt |
| core_wake | input | N_CORES | Per-core pulse: a break event woke the core |
| rsp_strobe | input | 1 | Response phase of the outstanding acknowledge cycle |
| bus_err_evt | input | 1 | Bus-initialization error event pulse |
| ack_req | output | N_DIES | Per-die acknowledge special cycle request |
| stop_grant | output | 1 | All cores are in stop-grant |
| core_state | output | 2*N_CORES | Per-core state: 00 running, 01 halted, 10 granted |
| proto_err | output | 1 | One-cycle pulse: request released before stop-grant |
| err_pending | output | 1 | Error event held during stop-grant |
| err_service | output | 1 | One-cycle pulse: error event handed on for service |

## Verification
Two functions can land in the same cycle: the sequencer leaving stop-grant, and a new bus-initialization error event arriving. The bench provokes this by raising the request pin and then presenting the error event in the cycle just before the synchronized release reaches the sequencer. Both then take effect on the same edge. The result is judged correct only if exactly one `err_service` pulse appears on the exit edge and `err_pending` stays low both before and after it.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  typedef enum logic [1:0] {
    CORE_RUN   = 2'b00,
    CORE_HALT  = 2'b01,
    CORE_GRANT = 2'b10
  } core_st_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ACK,
    SEQ_WAIT,
    SEQ_GRANT
  } seq_st_e;
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/stopclk_core_track.sv
module stopclk_core_track
  import stopclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_enter,
  input  logic       wake,
  input  logic       grant_enter,
  input  logic       grant_exit,
  output logic [1:0] st_o
);
  core_st_e st;
  logic     saved_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= CORE_RUN;
      saved_halt <= 1'b0;
    end else if (grant_enter) begin
      saved_halt <= (st == CORE_HALT);
      st         <= CORE_GRANT;
    end else if (grant_exit) begin
      st <= saved_halt ? CORE_HALT : CORE_RUN;
    end else if (st != CORE_GRANT) begin
      if (wake)            st <= CORE_RUN;
      else if (halt_enter) st <= CORE_HALT;
    end
  end

  assign st_o = st;

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CORE_GRANT && !grant_exit) |=> (st == CORE_GRANT));

  assert_exit_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_exit |=> (st != CORE_GRANT));
endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
  import stopclk_pkg::*;
#(
  parameter int N_DIES      = 2,
  parameter int GRANT_DELAY = 4,
  parameter int MAX_WINDOW  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              rsp_strobe,
  output logic [N_DIES-1:0] ack_req,
  output logic              stop_grant,
  output logic              grant_enter,
  output logic              grant_exit,
  output logic              proto_err
);
  localparam int CNT_W = $clog2(MAX_WINDOW + 1);
  localparam int DIE_W = (N_DIES > 1) ? $clog2(N_DIES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRANT_DELAY - 1);
  localparam logic [DIE_W-1:0] DIE_LAST = DIE_W'(N_DIES - 1);

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [DIE_W-1:0] die_idx;
  logic             early_rel;

  assign early_rel   = !req_s && (st == SEQ_ACK || st == SEQ_WAIT);
  assign grant_enter = (st == SEQ_WAIT) && req_s && (cnt == CNT_LAST);
  assign grant_exit  = (st == SEQ_GRANT) && !req_s;
  assign proto_err   = early_rel;
  assign stop_grant  = (st == SEQ_GRANT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      cnt     <= '0;
      die_idx <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: if (req_s) begin
          st      <= SEQ_ACK;
          die_idx <= '0;
        end
        SEQ_ACK: begin
          if (!req_s) st <= SEQ_IDLE;
          else if (rsp_strobe) begin
            cnt <= '0;
            if (die_idx == DIE_LAST) st <= SEQ_WAIT;
            else die_idx <= die_idx + 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (!req_s) st <= SEQ_IDLE;
          else if (cnt == CNT_LAST) st <= SEQ_GRANT;
          else cnt <= cnt + 1'b1;
        end
        SEQ_GRANT: if (!req_s) st <= SEQ_IDLE;
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  for (genvar d = 0; d < N_DIES; d++) begin : g_ack
    assign ack_req[d] = (st == SEQ_ACK) && (die_idx == DIE_W'(d));
  end

  initial begin
    assert_delay_param_R3: assert (GRANT_DELAY >= 1 && GRANT_DELAY <= MAX_WINDOW)
      else $error("grant delay out of range");
  end

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_req));

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_WAIT) |-> (cnt < CNT_W'(MAX_WINDOW)));

  assert_no_ack_in_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> (ack_req == '0));

  assert_early_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> (!stop_grant && ack_req == '0 && !proto_err));
endmodule

// File: rtl/stopclk_err.sv
module stopclk_err (
  input  logic clk,
  input  logic rst_n,
  input  logic in_grant,
  input  logic grant_exit,
  input  logic bus_err_evt,
  output logic err_pending,
  output logic err_service
);
  logic pend_q, svc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      if (grant_exit) pend_q <= 1'b0;
      else if (bus_err_evt && in_grant) pend_q <= 1'b1;
      svc_q <= (bus_err_evt && (!in_grant || grant_exit)) || (grant_exit && pend_q);
    end
  end

  assign err_pending = pend_q;
  assign err_service = svc_q;

  assert_pend_only_in_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pending |-> in_grant);

  assert_pend_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_exit && err_pending) |=> (err_service && !err_pending));

  assert_no_service_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_grant && !grant_exit) |=> !err_service);
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int N_CORES     = 4,
  parameter int N_DIES      = 2,
  parameter int GRANT_DELAY = 4,
  parameter int MAX_WINDOW  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_req_n,
  input  logic [N_CORES-1:0]   core_halt_enter,
  input  logic [N_CORES-1:0]   core_wake,
  input  logic                 rsp_strobe,
  input  logic                 bus_err_evt,
  output logic [N_DIES-1:0]    ack_req,
  output logic                 stop_grant,
  output logic [2*N_CORES-1:0] core_state,
  output logic                 proto_err,
  output logic                 err_pending,
  output logic                 err_service
);
  localparam logic [2*N_CORES-1:0] ALL_GRANT = {N_CORES{CORE_GRANT}};

  logic req_s, grant_enter, grant_exit;

  stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(!stop_req_n), .q(req_s)
  );

  stopclk_seq #(
    .N_DIES(N_DIES), .GRANT_DELAY(GRANT_DELAY), .MAX_WINDOW(MAX_WINDOW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .rsp_strobe(rsp_strobe),
    .ack_req(ack_req), .stop_grant(stop_grant), .grant_enter(grant_enter),
    .grant_exit(grant_exit), .proto_err(proto_err)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    stopclk_core_track u_core (
      .clk(clk), .rst_n(rst_n),
      .halt_enter(core_halt_enter[c]), .wake(core_wake[c]),
      .grant_enter(grant_enter), .grant_exit(grant_exit),
      .st_o(core_state[2*c +: 2])
    );
  end

  stopclk_err u_err (
    .clk(clk), .rst_n(rst_n), .in_grant(stop_grant), .grant_exit(grant_exit),
    .bus_err_evt(bus_err_evt), .err_pending(err_pending), .err_service(err_service)
  );

  assert_all_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> (core_state == ALL_GRANT));

  assert_grant_needs_cores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_grant) |-> $past(ack_req) == '0);
endmodule

// File: tb/tb_stopclk_ctrl.sv
module tb_stopclk_ctrl;
  localparam int NC = 4;
  localparam int ND = 2;
  localparam int GD = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stop_req_n = 1'b1;
  logic [NC-1:0]   core_halt_enter = '0;
  logic [NC-1:0]   core_wake = '0;
  logic            rsp_strobe = 1'b0;
  logic            bus_err_evt = 1'b0;
  logic [ND-1:0]   ack_req;
  logic            stop_grant;
  logic [2*NC-1:0] core_state;
  logic            proto_err, err_pending, err_service;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  stopclk_ctrl #(.N_CORES(NC), .N_DIES(ND), .GRANT_DELAY(GD)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .core_halt_enter(core_halt_enter), .core_wake(core_wake),
    .rsp_strobe(rsp_strobe), .bus_err_evt(bus_err_evt),
    .ack_req(ack_req), .stop_grant(stop_grant), .core_state(core_state),
    .proto_err(proto_err), .err_pending(err_pending), .err_service(err_service)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // R1, R2, R3, R4: request, per-die acknowledges, window count
  task automatic t_enter(input logic [2*NC-1:0] exp_pre);
    int n = 0;
    step(); stop_req_n = 1'b0;
    do begin step(); n++; end while (ack_req == '0 && n < 10);
    chk("R1 ack latency", n, 3);
    for (int d = 0; d < ND; d++) begin
      chk("R2 ack order", int'(ack_req), 1 << d);
      step(); step();
      chk("R2 ack held until strobe", int'(ack_req), 1 << d);
      chk("R2 no grant before last strobe", int'(stop_grant), 0);
      chk("R10 cores unchanged while acking", int'(core_state), int'(exp_pre));
      rsp_strobe = 1'b1; step(); rsp_strobe = 1'b0;
    end
    n = 0;
    while (!stop_grant && n < 40) begin step(); n++; end
    chk("R3 grant delay", n, GD);
    chk("R3 within 20", int'(n <= 20), 1);
    chk("R4 cores granted", int'(core_state), int'({NC{2'b10}}));
    chk("R2 acks idle in grant", int'(ack_req), 0);
  endtask

  task automatic t_release(input logic [2*NC-1:0] exp_post, input int exp_svc);
    int n = 0;
    step(); stop_req_n = 1'b1;
    do begin step(); n++; end while (stop_grant && n < 10);
    chk("R5 release latency", n, 3);
    chk("R5 cores restored", int'(core_state), int'(exp_post));
    chk("R8 service on exit", int'(err_service), exp_svc);
    chk("R8 pending clear on exit", int'(err_pending), 0);
    step();
    chk("R8 service single pulse", int'(err_service), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    chk("R11 ack", int'(ack_req), 0);
    chk("R11 grant", int'(stop_grant), 0);
    chk("R11 cores", int'(core_state), 0);
    chk("R11 flags", int'({proto_err, err_pending, err_service}), 0);
  endtask

  task automatic t_core_track();
    core_halt_enter = 4'b0111; step(); core_halt_enter = '0;
    chk("R10 halt entry", int'(core_state), int'(8'b00_01_01_01));
    core_wake = 4'b0010; core_halt_enter = 4'b0010; step();
    core_wake = '0; core_halt_enter = '0;
    chk("R10 wake wins", int'(core_state), int'(8'b00_01_00_01));
    rsp_strobe = 1'b1; step(); rsp_strobe = 1'b0; step();
    chk("R2 stray strobe ack", int'(ack_req), 0);
    chk("R2 stray strobe grant", int'(stop_grant), 0);
  endtask

  task automatic t_grant_cycle();
    logic [2*NC-1:0] pre = 8'b00_01_00_01;
    t_enter(pre);
    core_wake = '1; step(); core_wake = '0;
    chk("R7 wake ignored", int'(core_state), int'({NC{2'b10}}));
    core_halt_enter = '1; step(); core_halt_enter = '0;
    chk("R7 halt ignored", int'(core_state), int'({NC{2'b10}}));
    t_release(pre, 0);
  endtask

  task automatic t_early_release();
    int n = 0;
    logic [2*NC-1:0] pre = core_state;
    step(); stop_req_n = 1'b0;
    while (ack_req == '0 && n < 10) begin step(); n++; end
    stop_req_n = 1'b1; n = 0;
    do begin step(); n++; end while (!proto_err && n < 10);
    chk("R6 proto_err latency", n, 2);
    step();
    chk("R6 proto_err one cycle", int'(proto_err), 0);
    chk("R6 ack withdrawn", int'(ack_req), 0);
    chk("R6 no grant", int'(stop_grant), 0);
    chk("R6 cores kept", int'(core_state), int'(pre));
  endtask

  task automatic t_err_outside();
    bus_err_evt = 1'b1; step(); bus_err_evt = 1'b0;
    chk("R9 service now", int'(err_service), 1);
    chk("R9 not pending", int'(err_pending), 0);
    step();
    chk("R9 pulse ends", int'(err_service), 0);
  endtask

  task automatic t_err_inside();
    logic [2*NC-1:0] pre = core_state;
    t_enter(pre);
    bus_err_evt = 1'b1; step(); bus_err_evt = 1'b0;
    chk("R8 latched", int'(err_pending), 1);
    chk("R8 not serviced", int'(err_service), 0);
    step(); step();
    chk("R8 still held", int'(err_pending), 1);
    t_release(pre, 1);
  endtask

  task automatic t_err_same_cycle();
    logic [2*NC-1:0] pre = core_state;
    t_enter(pre);
    step(); stop_req_n = 1'b1;
    step(); step();
    chk("R9 still granted", int'(stop_grant), 1);
    bus_err_evt = 1'b1; step(); bus_err_evt = 1'b0;
    chk("R9 exit taken", int'(stop_grant), 0);
    chk("R9 same-cycle service", int'(err_service), 1);
    chk("R9 same-cycle no pending", int'(err_pending), 0);
    step();
    chk("R9 same-cycle single", int'(err_service), 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_core_track();
    t_grant_cycle();
    t_early_release();
    t_err_outside();
    t_err_inside();
    t_err_same_cycle();
    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule